// File: doc/BRIEF.md
# I2C Master START Sequencer

This block produces the opening START condition for the master side of an I2C bus. Software first loads a 7-bit reload value into the bit-period counter. It then sets the start bit in a small control register. The sequencer checks the two bus lines and counts one bit period with SDA released. If the bus is still free, it pulls SDA low while SCL stays high, which is the START. It then counts a second period and finishes, leaving SDA held low for the logic that sends the first byte. SCL is never driven by this block.

While the sequence runs, the block watches for other masters. Another master is assumed if:
- either line is low when the sequence begins,
- SCL drops before SDA has been pulled, or
- SDA is found low when the first period ends.

In each of these cases the attempt is aborted. A sticky bus-collision flag is raised, SDA is released and the sequencer returns to idle.

Software cannot queue anything while the start bit is set. A write to the transmit byte register raises a sticky write-collision flag and the stored byte stays as it was. Writes to the control register are dropped. The held-low SDA after completion is released only by reset or by a later collision abort, because the byte and STOP logic that would normally follow are outside this block.

Top module: `i2c_start_seq`

## Requirements
- R1: After reset, `sda_pull` is 0. `start_seen`, `done_flag`, `bcol_flag` and `wcol_flag` are 0. `ctrl_rd`, `txbuf_rd` and the reload value are 0.
- R2: The sequence starts on the first clock after the start bit (`ctrl_rd` bit 0) becomes 1. If both synchronized lines are high at that clock, the bit-period counter is loaded with the reload value and `start_seen` is cleared.
- R3: If a write setting the start bit is sampled at clock edge W with reload value N, then `sda_pull` becomes 1 and `start_seen` becomes 1 at edge W+N+2. Both are still 0 after edge W+N+1.
- R4: After edge W+2N+3 the start bit reads 0, `done_flag` is 1 and `sda_pull` stays 1. After edge W+2N+2 the start bit is still 1 and `done_flag` is 0.
- R5: If either synchronized line is low at the clock where the sequence would start, `bcol_flag` is set and the start bit is cleared on that edge, and `sda_pull` never rises.
- R6: During the first period, a low synchronized SCL, or a low synchronized SDA when the period ends, aborts the sequence. The abort sets `bcol_flag`, clears the start bit and `start_seen`, and keeps `sda_pull` at 0.
- R7: A `txbuf_wr` sampled while the start bit is 1 sets `wcol_flag` and leaves `txbuf_rd` unchanged. The same write with the start bit 0 stores the byte.
- R8: A `ctrl_wr` sampled while the start bit is 1 changes none of the 5 control bits. Bit 0 is start; bits 1 to 4 are repeated-start, stop, receive-enable and acknowledge-enable, which are stored only. With the start bit 0 the whole write is stored.
- R9: `done_flag`, `bcol_flag` and `wcol_flag` hold until their clear input is 1 at a clock edge. If a clear and a set fall on the same edge, the flag ends up set.
- R10: `sda_in` and `scl_in` pass through two flip-flop stages before the sequencer uses them. An SCL drop sampled at edge E is acted on at edge E+2.
- R11: A reload value of 0 makes each period one clock long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 5 | Control write data; bit 0 is start |
| reload_wr | input | 1 | Write strobe for the period reload value |
| reload_wdata | input | 7 | Period reload value |
| txbuf_wr | input | 1 | Write strobe for the transmit byte |
| txbuf_wdata | input | 8 | Transmit byte data |
| clr_done | input | 1 | Clears the completion flag |
| clr_bcol | input | 1 | Clears the bus-collision flag |
| clr_wcol | input | 1 | Clears the write-collision flag |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| sda_pull | output | 1 | Active-high pull-low enable for SDA |
| ctrl_rd | output | 5 | Control register contents |
| txbuf_rd | output | 8 | Transmit byte contents |
| start_seen | output | 1 | START has been placed on the bus |
| done_flag | output | 1 | Sticky completion flag |
| bcol_flag | output | 1 | Sticky bus-collision flag |
| wcol_flag | output | 1 | Sticky write-collision flag |

## Verification
The completion of the second period can land on the same clock edge as a software clear of the completion flag and as a write to the transmit byte. With a reload value of 0, both software actions are timed to be sampled exactly at edge W+3, when the start bit clears.

The bench expects the completion flag to survive the clear and the byte write to be rejected with the write-collision flag set. It also expects an identical byte write one edge later to be stored.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LEAD = 2'd1,
        SEQ_LOW  = 2'd2,
        SEQ_DONE = 2'd3
    } seq_state_e;

    localparam int CTRL_W   = 5;
    localparam int CB_START = 0;

    typedef struct packed {
        logic done;
        logic bcol;
        logic wcol;
        logic seen;
    } flag_t;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int              WIDTH  = 2,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] INIT  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_d,
    output logic [WIDTH-1:0] sync_q
);

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [WIDTH-1:0] q_r;
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q_r <= INIT;
                    else        q_r <= async_d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) q_r <= INIT;
                    else        q_r <= g_stage[s-1].q_r;
                end
            end
        end
    endgenerate

    assign sync_q = g_stage[STAGES-1].q_r;

endmodule

// File: rtl/i2cs_brg.sv
module i2cs_brg #(
    parameter int RW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [RW-1:0] reload_val,
    output logic          expired
);

    logic [RW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load) begin
            count_d = reload_val;
        end else if (run && (count_q != '0)) begin
            count_d = count_q - 1'b1;
        end
    end

    assign expired = run && (count_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // R2: a load takes the reload value on the next edge
    a_r2_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q == $past(reload_val)));

    // R11: one step per clock while running
    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && (count_q != '0)) |=> (count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
    import i2cs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic sda_s,
    input  logic scl_s,
    input  logic expired,
    output logic load,
    output logic run,
    output logic launch,
    output logic start_evt,
    output logic done_evt,
    output logic bcol_evt,
    output logic sda_pull
);

    typedef struct packed {
        seq_state_e st;
    } seq_regs_t;

    seq_regs_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        load      = 1'b0;
        launch    = 1'b0;
        start_evt = 1'b0;
        done_evt  = 1'b0;
        bcol_evt  = 1'b0;
        unique case (s_q.st)
            SEQ_IDLE, SEQ_DONE: begin
                if (start_req) begin
                    if (sda_s && scl_s) begin
                        load   = 1'b1;
                        launch = 1'b1;
                        s_d.st = SEQ_LEAD;
                    end else begin
                        bcol_evt = 1'b1;
                        s_d.st   = SEQ_IDLE;
                    end
                end
            end
            SEQ_LEAD: begin
                if (!scl_s || (expired && !sda_s)) begin
                    bcol_evt = 1'b1;
                    s_d.st   = SEQ_IDLE;
                end else if (expired) begin
                    load      = 1'b1;
                    start_evt = 1'b1;
                    s_d.st    = SEQ_LOW;
                end
            end
            SEQ_LOW: begin
                if (expired) begin
                    done_evt = 1'b1;
                    s_d.st   = SEQ_DONE;
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    assign run      = (s_q.st == SEQ_LEAD) || (s_q.st == SEQ_LOW);
    assign sda_pull = (s_q.st == SEQ_LOW)  || (s_q.st == SEQ_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.st <= SEQ_IDLE;
        else        s_q    <= s_d;
    end

    // R3: SDA is pulled only after the first period has run out
    a_r3_pull_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(expired && (s_q.st == SEQ_LEAD)));

    // R6: an abort leaves SDA released
    a_r6_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
        bcol_evt |=> !sda_pull);

endmodule

// File: rtl/i2c_start_seq.sv
module i2c_start_seq
    import i2cs_pkg::*;
#(
    parameter int RELOAD_W    = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic [CTRL_W-1:0]   ctrl_wdata,
    input  logic                reload_wr,
    input  logic [RELOAD_W-1:0] reload_wdata,
    input  logic                txbuf_wr,
    input  logic [DATA_W-1:0]   txbuf_wdata,
    input  logic                clr_done,
    input  logic                clr_bcol,
    input  logic                clr_wcol,
    input  logic                sda_in,
    input  logic                scl_in,
    output logic                sda_pull,
    output logic [CTRL_W-1:0]   ctrl_rd,
    output logic [DATA_W-1:0]   txbuf_rd,
    output logic                start_seen,
    output logic                done_flag,
    output logic                bcol_flag,
    output logic                wcol_flag
);

    localparam int LINES = 2;

    typedef struct packed {
        logic [CTRL_W-1:0]   ctrl;
        logic [RELOAD_W-1:0] reload;
        logic [DATA_W-1:0]   txbuf;
        flag_t               flags;
    } regs_t;

    regs_t r_d, r_q;

    logic [LINES-1:0] lines_s;
    logic sda_s, scl_s;
    logic load, run, launch, start_evt, done_evt, bcol_evt, expired;
    logic busy;

    i2cs_sync #(
        .WIDTH (LINES),
        .STAGES(SYNC_STAGES),
        .INIT  ({LINES{1'b1}})
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_d({scl_in, sda_in}),
        .sync_q (lines_s)
    );

    assign sda_s = lines_s[0];
    assign scl_s = lines_s[1];
    assign busy  = r_q.ctrl[CB_START];

    i2cs_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_req(busy),
        .sda_s    (sda_s),
        .scl_s    (scl_s),
        .expired  (expired),
        .load     (load),
        .run      (run),
        .launch   (launch),
        .start_evt(start_evt),
        .done_evt (done_evt),
        .bcol_evt (bcol_evt),
        .sda_pull (sda_pull)
    );

    i2cs_brg #(
        .RW(RELOAD_W)
    ) u_brg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .run       (run),
        .reload_val(r_q.reload),
        .expired   (expired)
    );

    always_comb begin
        r_d = r_q;
        if (ctrl_wr && !busy) begin
            r_d.ctrl = ctrl_wdata;
        end
        if (done_evt || bcol_evt) begin
            r_d.ctrl[CB_START] = 1'b0;
        end
        if (reload_wr) begin
            r_d.reload = reload_wdata;
        end
        if (clr_wcol) r_d.flags.wcol = 1'b0;
        if (txbuf_wr) begin
            if (busy) r_d.flags.wcol = 1'b1;
            else      r_d.txbuf      = txbuf_wdata;
        end
        if (launch || bcol_evt) r_d.flags.seen = 1'b0;
        if (start_evt)          r_d.flags.seen = 1'b1;
        if (clr_done) r_d.flags.done = 1'b0;
        if (done_evt) r_d.flags.done = 1'b1;
        if (clr_bcol) r_d.flags.bcol = 1'b0;
        if (bcol_evt) r_d.flags.bcol = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl_rd    = r_q.ctrl;
    assign txbuf_rd   = r_q.txbuf;
    assign start_seen = r_q.flags.seen;
    assign done_flag  = r_q.flags.done;
    assign bcol_flag  = r_q.flags.bcol;
    assign wcol_flag  = r_q.flags.wcol;

    // R4: completion clears start and keeps SDA held
    a_r4_done_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |=> (!ctrl_rd[CB_START] && sda_pull && done_flag));

    // R7: a rejected byte write leaves the buffer alone
    a_r7_txbuf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[CB_START] && txbuf_wr) |=> ($stable(txbuf_rd) && wcol_flag));

    // R8: control writes are dropped during a sequence
    a_r8_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[CB_START] && ctrl_wr && !done_evt && !bcol_evt) |=> $stable(ctrl_rd));

    // R9: collision flag holds without a clear
    a_r9_bcol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (bcol_flag && !clr_bcol) |=> bcol_flag);

    // R9: set wins over a same-edge clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && clr_done) |=> done_flag);

endmodule

// File: tb/tb_i2c_start_seq.sv
module tb_i2c_start_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic       reload_wr = 1'b0;
    logic [6:0] reload_wdata = '0;
    logic       txbuf_wr = 1'b0;
    logic [7:0] txbuf_wdata = '0;
    logic       clr_done = 1'b0, clr_bcol = 1'b0, clr_wcol = 1'b0;
    logic       frc_sda = 1'b0, frc_scl = 1'b0;
    logic       sda_in, scl_in, sda_pull;
    logic [4:0] ctrl_rd;
    logic [7:0] txbuf_rd;
    logic       start_seen, done_flag, bcol_flag, wcol_flag;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // open-drain bus: either side may pull a line low
    assign sda_in = ~(sda_pull | frc_sda);
    assign scl_in = ~frc_scl;

    i2c_start_seq dut (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .reload_wr(reload_wr), .reload_wdata(reload_wdata),
        .txbuf_wr(txbuf_wr), .txbuf_wdata(txbuf_wdata),
        .clr_done(clr_done), .clr_bcol(clr_bcol), .clr_wcol(clr_wcol),
        .sda_in(sda_in), .scl_in(scl_in), .sda_pull(sda_pull),
        .ctrl_rd(ctrl_rd), .txbuf_rd(txbuf_rd), .start_seen(start_seen),
        .done_flag(done_flag), .bcol_flag(bcol_flag), .wcol_flag(wcol_flag)
    );

    // signal selectors: 0 pull, 1 seen, 2 done, 3 bcol, 4 wcol, 5 start bit
    typedef struct {
        int    cyc;
        int    sel;
        logic  val;
        string tag;
    } exp_t;

    exp_t sb[$];

    function automatic logic pick(int sel);
        case (sel)
            0:       return sda_pull;
            1:       return start_seen;
            2:       return done_flag;
            3:       return bcol_flag;
            4:       return wcol_flag;
            default: return ctrl_rd[0];
        endcase
    endfunction

    task automatic expect_at(int c, int sel, logic v, string tag);
        sb.push_back('{c, sel, v, tag});
    endtask

    // monitor: pop and compare items whose cycle has come
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc <= cyc) begin
                checks++;
                if (sb[i].cyc < cyc || pick(sb[i].sel) !== sb[i].val) begin
                    errors++;
                    $display("FAIL %s cycle %0d sel %0d actual %b expected %b",
                             sb[i].tag, sb[i].cyc, sb[i].sel, pick(sb[i].sel), sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        frc_sda = 1'b0; frc_scl = 1'b0;
        ctrl_wr = 1'b0; reload_wr = 1'b0; txbuf_wr = 1'b0;
        clr_done = 1'b0; clr_bcol = 1'b0; clr_wcol = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_reload(logic [6:0] v);
        @(negedge clk);
        reload_wr = 1'b1; reload_wdata = v;
        @(negedge clk);
        reload_wr = 1'b0;
    endtask

    task automatic wr_txbuf(logic [7:0] v);
        @(negedge clk);
        txbuf_wr = 1'b1; txbuf_wdata = v;
        @(negedge clk);
        txbuf_wr = 1'b0;
    endtask

    task automatic wr_ctrl(logic [4:0] v);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    // launch a start write and push the expected timeline for reload n
    task automatic launch_start(int n, output int w);
        @(negedge clk);
        w = cyc + 1;
        expect_at(w + n + 1, 0, 1'b0, "R3 pull early");
        expect_at(w + n + 2, 0, 1'b1, "R3 pull");
        expect_at(w + n + 1, 1, 1'b0, "R3 seen early");
        expect_at(w + n + 2, 1, 1'b1, "R3 seen");
        expect_at(w + 2*n + 2, 5, 1'b1, "R4 start held");
        expect_at(w + 2*n + 2, 2, 1'b0, "R4 done early");
        expect_at(w + 2*n + 3, 5, 1'b0, "R4 start cleared");
        expect_at(w + 2*n + 3, 2, 1'b1, "R4 done");
        expect_at(w + 2*n + 3, 0, 1'b1, "R4 sda held");
        ctrl_wr = 1'b1; ctrl_wdata = 5'h01;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w;
        do_reset();

        // R1 reset state
        check("R1 sda_pull", sda_pull, 0);
        check("R1 flags", {start_seen, done_flag, bcol_flag, wcol_flag}, 0);
        check("R1 ctrl", ctrl_rd, 0);
        check("R1 txbuf", txbuf_rd, 0);

        // R7 idle write accepted
        wr_txbuf(8'hA5);
        check("R7 idle txbuf write", txbuf_rd, 8'hA5);

        // R2 R3 R4 with reload 3, R7 R8 writes mid-sequence
        wr_reload(7'd3);
        launch_start(3, w);
        expect_at(w + 1, 4, 1'b0, "R7 wcol early");
        expect_at(w + 2, 4, 1'b1, "R7 wcol set");
        expect_at(w + 2, 5, 1'b1, "R8 start kept");
        @(negedge clk);
        txbuf_wr = 1'b1; txbuf_wdata = 8'h3C;
        ctrl_wr = 1'b1; ctrl_wdata = 5'h1E;
        @(negedge clk);
        txbuf_wr = 1'b0; ctrl_wr = 1'b0;
        check("R8 ctrl ignored", ctrl_rd, 5'h01);
        wait_until(w + 12);
        check("R7 txbuf unchanged", txbuf_rd, 8'hA5);
        check("R4 ctrl after done", ctrl_rd, 5'h00);
        wr_ctrl(5'h10);
        check("R8 idle ctrl write", ctrl_rd, 5'h10);
        check("R4 sda still held", sda_pull, 1);

        // R9 clears
        @(negedge clk);
        clr_done = 1'b1; clr_wcol = 1'b1;
        @(negedge clk);
        clr_done = 1'b0; clr_wcol = 1'b0;
        check("R9 done cleared", done_flag, 0);
        check("R9 wcol cleared", wcol_flag, 0);

        // R11 reload 0; R9 and R7 collide with completion edge
        do_reset();
        wr_reload(7'd0);
        launch_start(0, w);
        expect_at(w + 3, 4, 1'b1, "R7 wcol at completion");
        expect_at(w + 4, 2, 1'b1, "R9 set wins over clear");
        expect_at(w + 2, 0, 1'b1, "R11 one-clock period");
        wait_until(w + 2);
        clr_done = 1'b1; txbuf_wr = 1'b1; txbuf_wdata = 8'h77;
        @(negedge clk);
        clr_done = 1'b0; txbuf_wdata = 8'h88;
        check("R7 completion-edge write rejected", txbuf_rd, 8'h00);
        @(negedge clk);
        txbuf_wr = 1'b0;
        check("R7 next write accepted", txbuf_rd, 8'h88);

        // R5 collision at start: SCL low
        do_reset();
        wr_reload(7'd4);
        frc_scl = 1'b1;
        repeat (4) @(negedge clk);
        w = cyc + 1;
        expect_at(w, 5, 1'b1, "R5 start set");
        expect_at(w, 3, 1'b0, "R5 bcol early");
        expect_at(w + 1, 3, 1'b1, "R5 bcol");
        expect_at(w + 1, 5, 1'b0, "R5 start cleared");
        expect_at(w + 8, 0, 1'b0, "R5 no pull");
        ctrl_wr = 1'b1; ctrl_wdata = 5'h01;
        @(negedge clk);
        ctrl_wr = 1'b0;
        wait_until(w + 9);
        clr_bcol = 1'b1;
        @(negedge clk);
        clr_bcol = 1'b0;
        check("R9 bcol cleared", bcol_flag, 0);

        // R5 both lines low
        frc_sda = 1'b1;
        repeat (3) @(negedge clk);
        w = cyc + 1;
        expect_at(w + 1, 3, 1'b1, "R5 both low bcol");
        expect_at(w + 1, 5, 1'b0, "R5 both low start cleared");
        ctrl_wr = 1'b1; ctrl_wdata = 5'h01;
        @(negedge clk);
        ctrl_wr = 1'b0;
        wait_until(w + 3);
        frc_sda = 1'b0; frc_scl = 1'b0;

        // R6 R10 SCL drops inside the first period
        do_reset();
        wr_reload(7'd20);
        launch_start(20, w);
        sb.delete();
        expect_at(w + 7, 3, 1'b0, "R10 bcol before sync delay");
        expect_at(w + 8, 3, 1'b1, "R6 R10 bcol after sync delay");
        expect_at(w + 8, 5, 1'b0, "R6 start cleared");
        expect_at(w + 30, 0, 1'b0, "R6 sda released");
        expect_at(w + 30, 1, 1'b0, "R6 no start seen");
        wait_until(w + 5);
        frc_scl = 1'b1;
        wait_until(w + 12);
        frc_scl = 1'b0;
        wait_until(w + 31);

        // R6 SDA low when the first period ends
        do_reset();
        wr_reload(7'd5);
        launch_start(5, w);
        sb.delete();
        expect_at(w + 6, 3, 1'b0, "R6 sda case early");
        expect_at(w + 7, 3, 1'b1, "R6 sda low at timeout");
        expect_at(w + 8, 0, 1'b0, "R6 sda case no pull");
        wait_until(w + 2);
        frc_sda = 1'b1;
        wait_until(w + 10);
        frc_sda = 1'b0;

        // R3 R4 largest reload
        do_reset();
        wr_reload(7'd127);
        launch_start(127, w);
        wait_until(w + 2*127 + 5);

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left %0d items", sb.size());
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule